// File: doc/BRIEF.md
# ADC Parallel Bus Host Sequencer

This block runs from a fast system clock and performs one complete sample on an external 12-bit successive-approximation converter with a parallel, three-state bus. A sample request holds the mux channel, the input span, the polarity, the acquisition style and the power-down code. The block drives the chip select and the write strobe to hand over the control word. It keeps the word on the bus for a programmable hold-off when acquisition is host-timed and then writes the conversion start. It lets go of the bus and waits for the converter's active-low interrupt. It then reads the 12-bit result and returns it with a one-cycle `done`. If the interrupt never arrives, the block gives up after a programmable number of cycles and pulses `timeout`.

Each strobe width, the data setup and the bus turnaround are counts of system clocks. They are derived from nanosecond parameters by rounding up, so a change of clock period only needs new parameter values. The controller is a single enumerated state machine: IDLE, WR1 (first write), GAP (hold-off between writes), WR2 (second write), REL (data hold after the last write), WAIT (interrupt wait), RD (read strobe) and TURN (bus turnaround). The transitions are:

- IDLE→WR1 on `start`.
- WR1→GAP when host-timed acquisition is requested and the write time has expired. Otherwise WR1→REL.
- GAP→WR2, WR2→REL and REL→WAIT each happen when the state's count expires.
- WAIT→RD when the synchronized interrupt is low.
- WAIT→IDLE on timeout.
- RD→TURN when the read time has expired.
- TURN→IDLE when the turnaround time has expired. This transition raises `done`.

Top module: `adc_bus_host`

## Requirements
- R1: After reset, `cnv_cs_n`, `cnv_wr_n` and `cnv_rd_n` are high. `cnv_dq_oe`, `busy`, `done` and `timeout` are low.
- R2: The control word places the power-down code in bits 7:6, the acquisition flag (1 = host-timed) in bit 5, the span in bit 4, polarity in bit 3 and the channel in bits 2:0. Bits 11:8 are zero.
- R3: Every write holds `cnv_cs_n` and `cnv_wr_n` low together for exactly WR_CYC = max(ceil(80 ns/T), ceil(60 ns/T)) clocks. During that time the word is driven and stable on `cnv_dq_out` with `cnv_dq_oe` high.
- R4: With the acquisition flag clear, a request produces exactly one write, carrying flag 0.
- R5: With the acquisition flag set, the first write carries flag 1. The write strobe then stays high for max(`acq_holdoff`,1) clocks. A second write follows, carrying flag 0 and the same channel, span, polarity and power-down code.
- R6: The data drive is held for one clock after the last write and is released before any read. `cnv_rd_n` is never low while `cnv_dq_oe` is high.
- R7: Once the synchronized interrupt is seen low, the block holds `cnv_cs_n` and `cnv_rd_n` low for exactly RD_CYC = ceil(120 ns/T)+1 clocks. It captures `cnv_dq_in` on the last of those clocks and presents it on `result`.
- R8: After the read strobe rises, all strobes stay high for ceil(70 ns/T) clocks. Then `done` pulses for one clock, and `busy` is low in that same clock.
- R9: If the interrupt is not seen within `irq_limit`+1 clocks of waiting, `timeout` pulses for one clock, no read is made, no `done` is given, and the block returns to IDLE.
- R10: `start` is ignored while `busy` is high. No extra write and no extra completion follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin one sample (taken in IDLE only) |
| req_chan | input | 3 | Mux channel |
| req_range | input | 1 | Span select |
| req_bipolar | input | 1 | 1 = bipolar (two's-complement result) |
| req_ext_acq | input | 1 | 1 = host-timed two-write acquisition |
| req_pwr | input | 2 | Power-down code sent in the word |
| acq_holdoff | input | HOLD_W | Clocks between the two writes |
| irq_limit | input | LIMIT_W | Interrupt wait limit in clocks |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-clock completion pulse |
| timeout | output | 1 | One-clock give-up pulse |
| result | output | 12 | Captured conversion result |
| cnv_cs_n | output | 1 | Converter chip select, active low |
| cnv_wr_n | output | 1 | Converter write strobe, active low |
| cnv_rd_n | output | 1 | Converter read strobe, active low |
| cnv_dq_out | output | 12 | Data driven toward the converter |
| cnv_dq_oe | output | 1 | Drive enable for `cnv_dq_out` |
| cnv_dq_in | input | 12 | Data read from the converter |
| cnv_irq_n | input | 1 | Converter ready interrupt, active low |

## Verification
The bench builds the block with a 5 ns clock and the default nanosecond values. Writes are therefore exactly 16 clocks, reads exactly 25 clocks and the turnaround exactly 14 clocks, so a rounding slip of one clock in any derived count shows as a wrong count. The converter model puts valid data on the bus only in the last clock of the read, so an early capture returns a wrong value. The bench drives a hold-off of 10 and of 0, which covers the floor of one clock. A wait limit of 60 makes a timeout reachable in a few hundred clocks.

// File: rtl/adc_host_pkg.sv
`timescale 1ns/1ps
package adc_host_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WR1,
        S_GAP,
        S_WR2,
        S_REL,
        S_WAIT,
        S_RD,
        S_TURN
    } host_state_t;

    typedef struct packed {
        logic [1:0] pwr;
        logic       ext;
        logic       rng;
        logic       bip;
        logic [2:0] chan;
    } sample_req_t;

    // nanoseconds to clocks, rounded up
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per);
        return (ns + per - 1) / per;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/adc_sync.sv
`timescale 1ns/1ps
module adc_sync #(
    parameter int unsigned STAGES  = 2,
    parameter bit          RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= RST_VAL;
                else        chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= {STAGES{RST_VAL}};
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/adc_cycle_timer.sv
`timescale 1ns/1ps
module adc_cycle_timer #(
    parameter int unsigned CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              remain <= '0;
        else if (load)           remain <= load_val;
        else if (remain != '0)   remain <= remain - 1'b1;
    end

    assign expired = (remain == '0);
endmodule

// File: rtl/adc_ctrl_word.sv
`timescale 1ns/1ps
module adc_ctrl_word import adc_host_pkg::*; #(
    parameter int unsigned DW = 12
) (
    input  sample_req_t   req,
    input  logic          acq_flag,
    output logic [DW-1:0] word
);
    always_comb begin
        word      = '0;
        word[7:6] = req.pwr;
        word[5]   = acq_flag;
        word[4]   = req.rng;
        word[3]   = req.bip;
        word[2:0] = req.chan;
    end
endmodule

// File: rtl/adc_bus_host.sv
`timescale 1ns/1ps
module adc_bus_host import adc_host_pkg::*; #(
    parameter int unsigned CLK_NS     = 5,
    parameter int unsigned STROBE_NS  = 80,
    parameter int unsigned SETUP_NS   = 60,
    parameter int unsigned RDV_NS     = 120,
    parameter int unsigned RELEASE_NS = 70,
    parameter int unsigned HOLD_W     = 8,
    parameter int unsigned LIMIT_W    = 16,
    parameter int unsigned DW         = 12,
    parameter int unsigned SYNC_STG   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [2:0]         req_chan,
    input  logic               req_range,
    input  logic               req_bipolar,
    input  logic               req_ext_acq,
    input  logic [1:0]         req_pwr,
    input  logic [HOLD_W-1:0]  acq_holdoff,
    input  logic [LIMIT_W-1:0] irq_limit,
    output logic               busy,
    output logic               done,
    output logic               timeout,
    output logic [DW-1:0]      result,
    output logic               cnv_cs_n,
    output logic               cnv_wr_n,
    output logic               cnv_rd_n,
    output logic [DW-1:0]      cnv_dq_out,
    output logic               cnv_dq_oe,
    input  logic [DW-1:0]      cnv_dq_in,
    input  logic               cnv_irq_n
);
    localparam int unsigned WR_CYC = umax(ns_to_cyc(STROBE_NS, CLK_NS), ns_to_cyc(SETUP_NS, CLK_NS));
    localparam int unsigned RD_CYC = umax(ns_to_cyc(RDV_NS, CLK_NS) + 1, ns_to_cyc(STROBE_NS, CLK_NS));
    localparam int unsigned TR_CYC = umax(ns_to_cyc(RELEASE_NS, CLK_NS), 1);
    localparam int unsigned CNT_W  = umax(LIMIT_W, HOLD_W) + 1;

    host_state_t state, state_nxt;

    sample_req_t        req_in, req_q, req_sel;
    logic [HOLD_W-1:0]  hold_q;
    logic [LIMIT_W-1:0] limit_q;
    logic [DW-1:0]      word_first, word_second;
    logic               irq_n_s;
    logic               irq_seen;
    logic               t_load, t_zero;
    logic [CNT_W-1:0]   t_val;

    assign req_in  = '{pwr: req_pwr, ext: req_ext_acq, rng: req_range,
                       bip: req_bipolar, chan: req_chan};
    assign req_sel = (state == S_IDLE) ? req_in : req_q;

    // request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q   <= '0;
            hold_q  <= '0;
            limit_q <= '0;
        end else if (state == S_IDLE && start) begin
            req_q   <= req_in;
            hold_q  <= acq_holdoff;
            limit_q <= irq_limit;
        end
    end

    adc_ctrl_word #(.DW(DW)) u_word_a (
        .req(req_sel), .acq_flag(req_sel.ext), .word(word_first)
    );
    adc_ctrl_word #(.DW(DW)) u_word_b (
        .req(req_sel), .acq_flag(1'b0), .word(word_second)
    );

    adc_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b1)) u_irq_sync (
        .clk(clk), .rst_n(rst_n), .d(cnv_irq_n), .q(irq_n_s)
    );
    assign irq_seen = !irq_n_s;

    adc_cycle_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .expired(t_zero)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nxt;
    end

    // next state
    always_comb begin
        state_nxt = state;
        unique case (state)
            S_IDLE: if (start)    state_nxt = S_WR1;
            S_WR1:  if (t_zero)   state_nxt = req_q.ext ? S_GAP : S_REL;
            S_GAP:  if (t_zero)   state_nxt = S_WR2;
            S_WR2:  if (t_zero)   state_nxt = S_REL;
            S_REL:  if (t_zero)   state_nxt = S_WAIT;
            S_WAIT: begin
                if (irq_seen)     state_nxt = S_RD;
                else if (t_zero)  state_nxt = S_IDLE;
            end
            S_RD:   if (t_zero)   state_nxt = S_TURN;
            S_TURN: if (t_zero)   state_nxt = S_IDLE;
            default:              state_nxt = S_IDLE;
        endcase
    end

    // timer load on every state change
    always_comb begin
        t_load = (state_nxt != state);
        t_val  = '0;
        unique case (state_nxt)
            S_WR1, S_WR2: t_val = CNT_W'(WR_CYC - 1);
            S_GAP:        t_val = (hold_q == '0) ? '0 : CNT_W'(hold_q) - 1'b1;
            S_REL:        t_val = '0;
            S_WAIT:       t_val = CNT_W'(limit_q);
            S_RD:         t_val = CNT_W'(RD_CYC - 1);
            S_TURN:       t_val = CNT_W'(TR_CYC - 1);
            default:      t_val = '0;
        endcase
    end

    // registered outputs, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnv_cs_n   <= 1'b1;
            cnv_wr_n   <= 1'b1;
            cnv_rd_n   <= 1'b1;
            cnv_dq_oe  <= 1'b0;
            cnv_dq_out <= '0;
            done       <= 1'b0;
            timeout    <= 1'b0;
            result     <= '0;
        end else begin
            cnv_cs_n  <= !(state_nxt inside {S_WR1, S_WR2, S_RD});
            cnv_wr_n  <= !(state_nxt inside {S_WR1, S_WR2});
            cnv_rd_n  <= !(state_nxt == S_RD);
            cnv_dq_oe <= (state_nxt inside {S_WR1, S_GAP, S_WR2, S_REL});
            if (state_nxt == S_WR1 && state == S_IDLE)
                cnv_dq_out <= word_first;
            else if (state_nxt == S_WR2 && state == S_GAP)
                cnv_dq_out <= word_second;
            else if (state_nxt inside {S_IDLE, S_WAIT, S_RD, S_TURN})
                cnv_dq_out <= '0;
            done    <= (state == S_TURN) && (state_nxt == S_IDLE);
            timeout <= (state == S_WAIT) && (state_nxt == S_IDLE);
            if (state == S_RD && state_nxt == S_TURN)
                result <= cnv_dq_in;
        end
    end

    assign busy = (state != S_IDLE);

endmodule

// File: rtl/adc_bus_host_chk.sv
`timescale 1ns/1ps
module adc_bus_host_chk #(
    parameter int unsigned WR_CYC = 16,
    parameter int unsigned RD_CYC = 25,
    parameter int unsigned DW     = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic          timeout,
    input logic          cnv_cs_n,
    input logic          cnv_wr_n,
    input logic          cnv_rd_n,
    input logic          cnv_dq_oe,
    input logic [DW-1:0] cnv_dq_out
);
    logic [15:0] wr_run, rd_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_run <= '0;
            rd_run <= '0;
        end else begin
            if (cnv_wr_n)            wr_run <= '0;
            else if (wr_run != '1)   wr_run <= wr_run + 1'b1;
            if (cnv_rd_n)            rd_run <= '0;
            else if (rd_run != '1)   rd_run <= rd_run + 1'b1;
        end
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cnv_cs_n && cnv_wr_n && cnv_rd_n));

    p_cs_with_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnv_wr_n || !cnv_rd_n) |-> !cnv_cs_n);

    p_wr_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cnv_wr_n) |-> (wr_run >= 16'(WR_CYC)));

    p_word_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnv_wr_n && $past(!cnv_wr_n)) |-> ($stable(cnv_dq_out) && cnv_dq_oe));

    p_no_clash_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cnv_rd_n |-> !cnv_dq_oe);

    p_rd_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cnv_rd_n) |-> (rd_run >= 16'(RD_CYC)));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && timeout));

    p_timeout_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> !timeout);

endmodule

bind adc_bus_host adc_bus_host_chk #(.WR_CYC(WR_CYC), .RD_CYC(RD_CYC), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .timeout(timeout),
    .cnv_cs_n(cnv_cs_n), .cnv_wr_n(cnv_wr_n), .cnv_rd_n(cnv_rd_n),
    .cnv_dq_oe(cnv_dq_oe), .cnv_dq_out(cnv_dq_out)
);

// File: tb/adc_bus_host_test.sv
`timescale 1ns/1ps
module adc_bus_host_test;
    localparam int CLK_NS = 5;
    localparam int WR_EXP = (80 + CLK_NS - 1) / CLK_NS;       // 16
    localparam int RD_EXP = (120 + CLK_NS - 1) / CLK_NS + 1;  // 25
    localparam int TR_EXP = (70 + CLK_NS - 1) / CLK_NS;       // 14
    localparam int CONV   = 30;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  req_chan = '0;
    logic        req_range = 1'b0, req_bipolar = 1'b0, req_ext_acq = 1'b0;
    logic [1:0]  req_pwr = '0;
    logic [7:0]  acq_holdoff = '0;
    logic [15:0] irq_limit = 16'd2000;
    logic        busy, done, timeout;
    logic [11:0] result;
    logic        cs_n, wr_n, rd_n, dq_oe;
    logic [11:0] dq_out;
    logic [11:0] dq_in = '0;
    logic        irq_n = 1'b1;

    always #2.5 clk = ~clk;

    adc_bus_host uut (
        .clk(clk), .rst_n(rst_n), .start(start), .req_chan(req_chan),
        .req_range(req_range), .req_bipolar(req_bipolar), .req_ext_acq(req_ext_acq),
        .req_pwr(req_pwr), .acq_holdoff(acq_holdoff), .irq_limit(irq_limit),
        .busy(busy), .done(done), .timeout(timeout), .result(result),
        .cnv_cs_n(cs_n), .cnv_wr_n(wr_n), .cnv_rd_n(rd_n),
        .cnv_dq_out(dq_out), .cnv_dq_oe(dq_oe), .cnv_dq_in(dq_in), .cnv_irq_n(irq_n)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [11:0] res_of(input logic [11:0] w);
        return {w[2:0], w[7:3] ^ 5'b10110, ~w[3:0]};
    endfunction

    typedef struct { logic [11:0] res; bit to; } exp_t;
    exp_t        sq[$];
    logic [11:0] wq[$];

    // converter model state
    bit          no_irq = 0;
    int          exp_gap = 1;
    bit          wr_prev = 1, rd_prev = 1, wr_ok = 1, gap_on = 0;
    int          wr_run = 0, rd_run = 0, gap_run = 0, rel_run = 0, conv_cnt = 0;
    int          writes = 0, reads = 0;
    logic [11:0] wr_word = '0, cur_word = '0, res_hold = '0, exp_w;
    exp_t        e;

    // converter model and scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            // writes
            if (!wr_n) begin
                if (wr_prev) begin
                    wr_run = 0; wr_ok = 1; wr_word = dq_out;
                    if (gap_on) begin
                        chk(gap_run == exp_gap, "R5 hold-off clocks", gap_run, exp_gap);
                        gap_on = 0;
                    end
                end
                wr_run++;
                if (!dq_oe || cs_n || dq_out != wr_word) wr_ok = 0;
            end else if (!wr_prev) begin
                writes++;
                chk(wr_run == WR_EXP, "R3 write low clocks", wr_run, WR_EXP);
                chk(wr_ok, "R3 word held with cs low", wr_ok, 1);
                if (wq.size() == 0) chk(0, "R10 unexpected write", wr_word, 0);
                else begin
                    exp_w = wq.pop_front();
                    chk(wr_word == exp_w, "R2 control word", wr_word, exp_w);
                end
                irq_n = 1'b1;
                if (wr_word[5]) begin gap_on = 1; gap_run = 1; end
                else begin
                    cur_word = wr_word;
                    if (!no_irq) conv_cnt = CONV;
                end
            end else if (gap_on) gap_run++;
            wr_prev = wr_n;
            // conversion
            if (conv_cnt > 0) begin
                conv_cnt--;
                if (conv_cnt == 0) begin irq_n = 1'b0; res_hold = res_of(cur_word); end
            end
            // reads
            if (!rd_n) begin
                if (rd_prev) begin
                    rd_run = 0; irq_n = 1'b1; reads++;
                    chk(!cs_n, "R7 cs low with read", cs_n, 0);
                end
                rd_run++;
                if (dq_oe) chk(0, "R6 host drives during read", dq_oe, 0);
                dq_in = (rd_run >= RD_EXP) ? res_hold : 12'h000;
                rel_run = 0;
            end else begin
                if (!rd_prev) chk(rd_run == RD_EXP, "R7 read low clocks", rd_run, RD_EXP);
                dq_in = 12'h000;
            end
            rd_prev = rd_n;
            // monitor
            if (done) begin
                if (sq.size() == 0) chk(0, "R10 unexpected done", result, 0);
                else begin
                    e = sq.pop_front();
                    chk(!e.to, "R9 done where timeout expected", 1, 0);
                    chk(result == e.res, "R7 result", result, e.res);
                    chk(rel_run == TR_EXP, "R8 turnaround clocks", rel_run, TR_EXP);
                    chk(!busy, "R8 busy low with done", busy, 0);
                end
            end
            if (timeout) begin
                if (sq.size() == 0) chk(0, "R10 unexpected timeout", 1, 0);
                else begin
                    e = sq.pop_front();
                    chk(e.to, "R9 timeout", 0, 1);
                end
            end
            if (rd_n) rel_run++;
        end
    end

    task automatic run(input logic [2:0] ch, input bit rng, input bit bip, input bit ext,
                       input logic [1:0] pwr, input logic [7:0] hold, input bit quiet,
                       input bit poke);
        logic [11:0] w1, w2;
        w1 = {4'h0, pwr, ext, rng, bip, ch};
        w2 = w1; w2[5] = 1'b0;
        wq.push_back(w1);
        if (ext) wq.push_back(w2);
        sq.push_back('{res: res_of(w2), to: quiet});
        exp_gap = (hold == 0) ? 1 : int'(hold);
        no_irq  = quiet;
        @(negedge clk);
        req_chan = ch; req_range = rng; req_bipolar = bip; req_ext_acq = ext;
        req_pwr = pwr; acq_holdoff = hold; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy, "R4 busy after start", busy, 1);
        if (poke) begin
            repeat (20) @(negedge clk);
            req_chan = ~ch; req_ext_acq = ~ext; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int w0, r0;
        repeat (4) @(negedge clk);
        chk(cs_n && wr_n && rd_n, "R1 strobes high in reset", {cs_n, wr_n, rd_n}, 7);
        chk(!dq_oe && !busy, "R1 idle in reset", {dq_oe, busy}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!done && !timeout, "R1 no pulses after reset", {done, timeout}, 0);
        chk(cs_n && !dq_oe, "R1 bus idle", {cs_n, dq_oe}, 2);

        // R4 single-write samples
        run(3'd0, 0, 0, 0, 2'b00, 8'd0, 0, 0);
        run(3'd5, 1, 1, 0, 2'b10, 8'd0, 0, 0);
        run(3'd3, 0, 1, 0, 2'b11, 8'd0, 0, 0);
        // R5 two-write samples
        run(3'd2, 1, 0, 1, 2'b01, 8'd10, 0, 0);
        run(3'd4, 0, 1, 1, 2'b10, 8'd0, 0, 0);
        // R9 missing interrupt
        irq_limit = 16'd60;
        r0 = reads;
        run(3'd1, 1, 1, 0, 2'b00, 8'd0, 1, 0);
        chk(reads == r0, "R9 no read after timeout", reads - r0, 0);
        chk(!busy, "R9 back to idle", busy, 0);
        irq_limit = 16'd2000;
        // R10 start while busy
        w0 = writes;
        run(3'd6, 0, 0, 0, 2'b01, 8'd0, 0, 1);
        repeat (100) @(negedge clk);
        chk(writes - w0 == 1, "R10 writes for one request", writes - w0, 1);
        chk(!busy, "R10 idle after ignored start", busy, 0);
        // recovery after all of the above
        run(3'd7, 1, 1, 1, 2'b11, 8'd3, 0, 0);

        chk(wq.size() == 0, "R2 all words written", wq.size(), 0);
        chk(sq.size() == 0, "R8 all completions seen", sq.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule